// File: doc/BRIEF.md
# Service-Sequence Watchdog Timer with Early-Warning Interrupt

This block is a 16-bit register-mapped watchdog. Once armed, it divides the core clock by a parameterised prescale factor into coarse counts and counts down from a programmable 8-bit timeout. Software keeps it alive only by writing a fixed two-word key pair to the service register. A programmable number of counts before expiry, the block raises a maskable early-warning interrupt. At expiry, if reset assertion is armed, the block pulses a reset-request output and records the cause.

Software can also request a reset through a control bit. Several control fields are protected by write-once locks, so that errant firmware cannot disarm the watchdog once it has been configured. Access is through a flat bus with one write strobe and a combinational read mux. Five 16-bit registers sit at byte offsets 0x0, 0x2, 0x4, 0x6 and 0x8. Any other offset reads zero.

Top module: `wdog_timer`

## Requirements
- R1: Offset 0x0 is control, 0x2 is service (always reads 0x0000), 0x4 is reset cause, 0x6 is interrupt control and 0x8 is miscellaneous. After reset they read 0x0000, 0x0000, 0x0000, 0x0004 and 0x0001, and `irq_o` and `rst_req_o` are low.
- R2: Control bits 7, 1 and 0 take the value of the first control write after reset. Later writes leave them unchanged.
- R3: Control bit 2 (enable) and bit 3 (reset-assertion arm) can be set by a write but never cleared by one.
- R4: Counting runs only while bit 2 is set. The rising edge of bit 2 loads the counter from control bits [15:8] (T) and restarts the prescaler. Expiry occurs (T+1)×P clock edges after a load, where P is the prescale factor. At expiry the counter reloads and keeps running. If bit 3 is set, `rst_req_o` is high for exactly the one cycle after the expiry edge and the reset-cause register reads 0x0002. If bit 3 is clear, there is no pulse and the cause register is unchanged.
- R5: A write of 0x5555 followed by a write of 0xAAAA to the service register reloads the counter and prescaler. Any other word breaks the sequence. A lone 0xAAAA is ignored.
- R6: A service reload landing on the same edge as an expiry wins: no reset request is issued, and the next expiry is (T+1)×P edges later.
- R7: Interrupt-control bit 14 (status) sets on the edge where the counter takes a value equal to bits [7:0] (interval) while bit 15 (enable) is 1. `irq_o` equals status AND enable. With enable at 0 the status stays 0.
- R8: Writing 1 to interrupt-control bit 14 clears the status. A status set on the same edge takes priority over the clear.
- R9: Interrupt-control bit 15 and bits [7:0] take the value of the first write to that register after reset and are frozen afterwards.
- R10: Writing 1 to control bit 4 gives a one-cycle `rst_req_o` pulse and sets the cause register to 0x0001. Bit 4 always reads 0.
- R11: Control bit 5 is freely writable and drives `wda_o`.
- R12: Miscellaneous bit 0 is freely readable and writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle reset-request pulse |
| wda_o | output | 1 | Level driven from control bit 5 |

## Verification
Two pairs of events can coincide on one edge. The first pair is a service completion and a counter expiry. The second pair is a status-clear write and an early-warning set. The bench counts edges from a known load and issues the 0xAAAA write so that it lands exactly on the computed expiry edge. It then judges the outcome by the absence of a reset pulse and by the timing of the next expiry. In the same way, it places a write-1-to-clear on the edge where the interval is reached and requires `irq_o` to stay high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [3:0]  A_CTL  = 4'h0;
  localparam logic [3:0]  A_SVC  = 4'h2;
  localparam logic [3:0]  A_RSTS = 4'h4;
  localparam logic [3:0]  A_IRQ  = 4'h6;
  localparam logic [3:0]  A_MISC = 4'h8;

  localparam logic [15:0] SVC_KEY_A = 16'h5555;
  localparam logic [15:0] SVC_KEY_B = 16'hAAAA;

  localparam logic [7:0]  IV_RESET = 8'h04;

  typedef enum logic {
    SVC_IDLE  = 1'b0,
    SVC_ARMED = 1'b1
  } svc_state_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_n_o = ff2_q;
endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq import wdog_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  output logic        reload_o
);
  svc_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    reload_o = 1'b0;
    if (wr_i) begin
      case (state_q)
        SVC_IDLE:  if (wdata_i == SVC_KEY_A) state_d = SVC_ARMED;
        SVC_ARMED: begin
          reload_o = (wdata_i == SVC_KEY_B);
          state_d  = SVC_IDLE;
        end
        default:   state_d = SVC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SVC_IDLE;
    else        state_q <= state_d;
  end

  AST_SVC_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |=> (state_q == SVC_IDLE)); // R5
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TICKS_PER_COUNT = 16384,
  parameter int CNT_W           = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] pre_iv_i,
  output logic             expire_o,
  output logic             pre_hit_o
);
  localparam int PRE_W = (TICKS_PER_COUNT > 1) ? $clog2(TICKS_PER_COUNT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_COUNT - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick, upd;

  assign tick = en_i && (pre_q == PRE_LAST);

  always_comb begin
    pre_d    = pre_q;
    cnt_d    = cnt_q;
    upd      = 1'b0;
    expire_o = 1'b0;
    if (load_i) begin
      pre_d = '0;
      cnt_d = top_i;
      upd   = 1'b1;
    end else if (tick) begin
      pre_d = '0;
      upd   = 1'b1;
      if (cnt_q == '0) begin
        expire_o = 1'b1;
        cnt_d    = top_i;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (en_i) begin
      pre_d = pre_q + 1'b1;
    end
  end

  assign pre_hit_o = upd && (cnt_d == pre_iv_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R4
  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(top_i))); // R4
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer import wdog_pkg::*; #(
  parameter int TICKS_PER_COUNT = 16384,
  parameter int TOUT_W          = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_o,
  output logic        rst_req_o,
  output logic        wda_o
);
  localparam int PAD_W = 8 - TOUT_W;

  logic rst_s_n;
  logic wr_ctl, wr_svc, wr_irq, wr_misc;
  logic svc_reload, cnt_load, expire, pre_hit, sw_rst, to_rst;

  logic [TOUT_W-1:0] tout_q, tout_d;
  logic wdw_q, wdw_d, wda_q, wda_d, wdt_q, wdt_d, wde_q, wde_d;
  logic dbg_q, dbg_d, sus_q, sus_d, lock_q, lock_d;
  logic ie_q, ie_d, ist_q, ist_d, ilock_q, ilock_d;
  logic [TOUT_W-1:0] iv_q, iv_d;
  logic [1:0] rsts_q, rsts_d;
  logic pde_q, pde_d, rst_req_q, rst_req_d;

  wdog_rst_sync u_rsync (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s_n));

  assign wr_ctl  = bus_we && (bus_addr == A_CTL);
  assign wr_svc  = bus_we && (bus_addr == A_SVC);
  assign wr_irq  = bus_we && (bus_addr == A_IRQ);
  assign wr_misc = bus_we && (bus_addr == A_MISC);

  wdog_svc_seq u_svc (
    .clk(clk), .rst_n(rst_s_n), .wr_i(wr_svc), .wdata_i(bus_wdata),
    .reload_o(svc_reload)
  );

  assign cnt_load = (wde_d && !wde_q) || svc_reload;

  wdog_counter #(.TICKS_PER_COUNT(TICKS_PER_COUNT), .CNT_W(TOUT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .en_i(wde_q), .load_i(cnt_load),
    .top_i(tout_d), .pre_iv_i(iv_q), .expire_o(expire), .pre_hit_o(pre_hit)
  );

  // control register: free, sticky-set and write-once fields
  always_comb begin
    tout_d = tout_q; wda_d = wda_q; wdt_d = wdt_q; wde_d = wde_q;
    wdw_d  = wdw_q;  dbg_d = dbg_q; sus_d = sus_q; lock_d = lock_q;
    sw_rst = 1'b0;
    if (wr_ctl) begin
      tout_d = bus_wdata[8 +: TOUT_W];
      wda_d  = bus_wdata[5];
      wdt_d  = wdt_q | bus_wdata[3];
      wde_d  = wde_q | bus_wdata[2];
      sw_rst = bus_wdata[4];
      lock_d = 1'b1;
      if (!lock_q) begin
        wdw_d = bus_wdata[7];
        dbg_d = bus_wdata[1];
        sus_d = bus_wdata[0];
      end
    end
  end

  // interrupt control, reset cause, misc
  always_comb begin
    ie_d = ie_q; iv_d = iv_q; ist_d = ist_q; ilock_d = ilock_q;
    if (wr_irq) begin
      ilock_d = 1'b1;
      if (!ilock_q) begin
        ie_d = bus_wdata[15];
        iv_d = bus_wdata[TOUT_W-1:0];
      end
      if (bus_wdata[14]) ist_d = 1'b0;
    end
    if (pre_hit && ie_q) ist_d = 1'b1;

    to_rst    = expire && wdt_q;
    rst_req_d = to_rst || sw_rst;
    rsts_d    = rst_req_d ? {to_rst, sw_rst} : rsts_q;
    pde_d     = wr_misc ? bus_wdata[0] : pde_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tout_q <= '0; wdw_q <= 1'b0; wda_q <= 1'b0; wdt_q <= 1'b0;
      wde_q  <= 1'b0; dbg_q <= 1'b0; sus_q <= 1'b0; lock_q <= 1'b0;
      ie_q   <= 1'b0; iv_q <= TOUT_W'(IV_RESET); ist_q <= 1'b0; ilock_q <= 1'b0;
      rsts_q <= 2'b00; pde_q <= 1'b1; rst_req_q <= 1'b0;
    end else begin
      tout_q <= tout_d; wdw_q <= wdw_d; wda_q <= wda_d; wdt_q <= wdt_d;
      wde_q  <= wde_d;  dbg_q <= dbg_d; sus_q <= sus_d; lock_q <= lock_d;
      ie_q   <= ie_d;   iv_q <= iv_d;   ist_q <= ist_d; ilock_q <= ilock_d;
      rsts_q <= rsts_d; pde_q <= pde_d; rst_req_q <= rst_req_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = {{PAD_W{1'b0}}, tout_q, wdw_q, 1'b0, wda_q, 1'b0,
                            wdt_q, wde_q, dbg_q, sus_q};
      A_RSTS:  bus_rdata = {14'b0, rsts_q};
      A_IRQ:   bus_rdata = {ie_q, ist_q, 6'b0, {PAD_W{1'b0}}, iv_q};
      A_MISC:  bus_rdata = {15'b0, pde_q};
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign irq_o     = ist_q && ie_q;
  assign rst_req_o = rst_req_q;
  assign wda_o     = wda_q;

  AST_WDE_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    wde_q |=> wde_q); // R3
  AST_WDT_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    wdt_q |=> wdt_q); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    lock_q |=> $stable({wdw_q, dbg_q, sus_q})); // R2
  AST_ILOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    ilock_q |=> $stable({ie_q, iv_q})); // R9
  AST_IST_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ist_q) |-> ie_q); // R7
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int P = 4;
  localparam logic [3:0] A_CTL = 4'h0, A_SVC = 4'h2, A_RSTS = 4'h4,
                         A_IRQ = 4'h6, A_MISC = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o, rst_req_o, wda_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_e = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer #(.TICKS_PER_COUNT(P)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .wda_o(wda_o)
  );

  typedef struct packed {
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{A_CTL,  16'h0AA1, 16'h0AA1},  // R2 first write takes group; R11
    '{A_CTL,  16'h0A02, 16'h0A81},  // R2 group frozen, bit5 free
    '{A_MISC, 16'h0000, 16'h0000},  // R12
    '{A_MISC, 16'h0001, 16'h0001},  // R12
    '{A_IRQ,  16'h8003, 16'h8003},  // R9 first write
    '{A_IRQ,  16'h0005, 16'h8003},  // R9 frozen
    '{A_SVC,  16'h5555, 16'h0000},  // R1 service reads zero
    '{A_SVC,  16'h1234, 16'h0000}   // R5 breaks sequence
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    last_e = cyc;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e, s;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rd("R1", A_CTL,  16'h0000);
    rd("R1", A_SVC,  16'h0000);
    rd("R1", A_RSTS, 16'h0000);
    rd("R1", A_IRQ,  16'h0004);
    rd("R1", A_MISC, 16'h0001);
    chk("R1", {14'b0, irq_o, rst_req_o}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    foreach (VECS[i]) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd("R2/R9/R12 table", VECS[i].addr, VECS[i].exp);
    end
    chk("R11 wda low", {15'b0, wda_o}, 16'h0000);

    // enable with T=10, reset assertion armed, bit5 set
    wr(A_CTL, 16'h0AAD); e = last_e;
    chk("R11 wda high", {15'b0, wda_o}, 16'h0001);
    wr(A_CTL, 16'h0A81);
    rd("R3 sticky enable/arm", A_CTL, 16'h0A8D);
    wait_until(e + 27); chk("R7 before interval", {15'b0, irq_o}, 16'h0000);
    wait_until(e + 28); chk("R7 at interval", {15'b0, irq_o}, 16'h0001);
    wait_until(e + 43); chk("R4 before expiry", {15'b0, rst_req_o}, 16'h0000);
    wait_until(e + 44); chk("R4 expiry pulse", {15'b0, rst_req_o}, 16'h0001);
    rd("R4 cause timeout", A_RSTS, 16'h0002);
    wait_until(e + 45); chk("R4 pulse one cycle", {15'b0, rst_req_o}, 16'h0000);
    wr(A_IRQ, 16'h4000);
    chk("R8 clear", {15'b0, irq_o}, 16'h0000);
    rd("R9 still frozen", A_IRQ, 16'h8003);

    // service sequence, then broken attempts that must not reload
    wr(A_SVC, 16'h5555);
    wr(A_SVC, 16'hAAAA); s = last_e;
    wr(A_SVC, 16'hAAAA);
    wr(A_SVC, 16'h5555);
    wr(A_SVC, 16'h1234);
    wr(A_SVC, 16'hAAAA);
    wait_until(s + 27); chk("R5 reload timing irq", {15'b0, irq_o}, 16'h0000);
    wait_until(s + 28); chk("R5 reload timing irq", {15'b0, irq_o}, 16'h0001);
    wait_until(s + 43); chk("R5 no early expiry", {15'b0, rst_req_o}, 16'h0000);
    wait_until(s + 44); chk("R5 stray words ignored", {15'b0, rst_req_o}, 16'h0001);
    wr(A_IRQ, 16'h4000);
    chk("R8 clear again", {15'b0, irq_o}, 16'h0000);

    // clear coinciding with a set: set wins
    wait_until(s + 71);
    wr(A_IRQ, 16'h4000);
    chk("R8 set beats clear", {15'b0, irq_o}, 16'h0001);

    // service completion on the expiry edge
    wr(A_SVC, 16'h5555);
    wait_until(s + 87);
    wr(A_SVC, 16'hAAAA);
    chk("R6 no pulse on collision", {15'b0, rst_req_o}, 16'h0000);
    @(negedge clk);
    chk("R6 no pulse after collision", {15'b0, rst_req_o}, 16'h0000);
    wait_until(s + 131); chk("R6 next expiry not early", {15'b0, rst_req_o}, 16'h0000);
    wait_until(s + 132); chk("R6 next expiry", {15'b0, rst_req_o}, 16'h0001);
    @(negedge clk);

    // software reset
    wr(A_CTL, 16'h0A9D);
    chk("R10 pulse", {15'b0, rst_req_o}, 16'h0001);
    rd("R10 cause software", A_RSTS, 16'h0001);
    rd("R10 bit4 reads zero", A_CTL, 16'h0A8D);
    @(negedge clk);
    chk("R10 pulse one cycle", {15'b0, rst_req_o}, 16'h0000);

    // second run: arm off, interrupt disabled
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rd("R1 reset again", A_CTL, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(A_CTL, 16'h0604); e = last_e;
    wait_until(e + 8);
    rd("R7 no status without enable", A_IRQ, 16'h0004);
    chk("R7 irq low", {15'b0, irq_o}, 16'h0000);
    wait_until(e + 28);
    chk("R4 no pulse when unarmed", {15'b0, rst_req_o}, 16'h0000);
    rd("R4 cause unchanged", A_RSTS, 16'h0000);
    wait_until(e + 29);
    chk("R4 no pulse when unarmed", {15'b0, rst_req_o}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule